// File: doc/BRIEF.md
# SDA Line Conditioner

This block sits between an I2C byte engine and the SDA pad. On the output side it holds back every change of the requested SDA drive level by a programmable number of input clocks. That guarantees data hold time after SCL falls. On the input side it can clean the sampled pad level with a digital glitch filter before the engine sees it.

A 3-bit line-control word configures both directions. Its low two bits select the output delay in steps of five input clocks. Code 0 means no delay. The 2-bit field cannot express more than 3, so the delay saturates at fifteen clocks. The top bit switches the input filter on or off.

A change of the requested level restarts the delay count. Because of this, a request pulse shorter than the delay never reaches the pad. When the filter is on, a new input level is accepted only after it has been seen on three consecutive clock edges.

Top module: `sda_line_conditioner`

## Requirements
- R1: `lineCtrl[1:0]` is the delay code and `lineCtrl[2]` is the input filter enable (1 = filter on).
- R2: With delay code 0, `sdaPadOut` equals `sdaReq` in the same cycle, with no clock edge in between.
- R3: With delay code N (1 to 3), a change of `sdaReq` held stable reaches `sdaPadOut` exactly 5×N rising clock edges after it was applied, counting the first edge that samples it.
- R4: Any change of `sdaReq` restarts the delay. A request pulse that returns to the driven level before the delay expires never appears on `sdaPadOut`, and the output then follows the last change 5×N edges after that change.
- R5: With the filter on, `sdaIn` takes a new level on the third consecutive rising edge that samples that level on `sdaPadIn`. Pulses of one or two cycles leave `sdaIn` unchanged.
- R6: With the filter off, `sdaIn` equals `sdaPadIn` in the same cycle.
- R7: While `rst_n` is low, the stored drive level is 1 (so `sdaPadOut` is 1 for a nonzero code) and the filter output is 1. The delay counter is cleared, so a low request held through reset reaches the pad exactly 5×N edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that times the delay and the filter |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineCtrl | input | 3 | Line-control word: delay code in bits 1:0, filter enable in bit 2 |
| sdaReq | input | 1 | SDA level requested by the byte engine (1 = released) |
| sdaPadIn | input | 1 | Raw SDA level sampled from the pad |
| sdaPadOut | output | 1 | Delayed SDA drive level toward the pad |
| sdaIn | output | 1 | SDA level returned to the byte engine, filtered when enabled |

## Verification
The bench measures the edge count from a request change to the pad for every code, in both directions. An off-by-one in the counter load shows up as a delay of 5×N±1. A design that does not restart the counter on each change either lets a short pulse reach the pad or moves the late edge too early. Input pulses of one, two, three and six cycles separate a filter window of the wrong length from a correct one. A reset with a low request held through it exposes a counter that is not cleared, or a drive level that does not reset to released.

// File: rtl/sda_cond_pkg.sv
package sda_cond_pkg;

  // Strobes from the delay control to the drive-level datapath
  typedef struct packed {
    logic bypass;   // delay code is zero: pass the request straight through
    logic restart;  // request differs from the last captured level
    logic commit;   // delay expired: copy the captured level to the pad
  } sdaStrobe_t;

endpackage

// File: rtl/sda_delay_ctrl.sv
module sda_delay_ctrl
  import sda_cond_pkg::*;
#(
  parameter int STEP   = 5,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              reqChanged,
  output sdaStrobe_t        strobe
);

  localparam int MAX_DLY = ((1 << CODE_W) - 1) * STEP;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // The edge that loads the counter is the first of the delay edges.
  always_comb begin
    loadVal = CNT_W'(int'(code) * STEP - 1);
  end

  always_comb begin
    strobe.bypass  = (code == '0);
    strobe.restart = !strobe.bypass && reqChanged;
    strobe.commit  = !strobe.bypass && !reqChanged && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.bypass) begin
      cnt <= '0;
    end else if (strobe.restart) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sda_delay_path.sv
module sda_delay_path
  import sda_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdaReq,
  input  sdaStrobe_t strobe,
  output logic       reqChanged,
  output logic       sdaPadOut
);

  logic reqQ;   // last captured request level
  logic held;   // level currently driven when the delay is active

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ <= 1'b1;
      held <= 1'b1;
    end else begin
      if (strobe.bypass || strobe.restart) reqQ <= sdaReq;
      if (strobe.bypass)                   held <= sdaReq;
      else if (strobe.commit)              held <= reqQ;
    end
  end

  assign reqChanged = (sdaReq != reqQ);
  assign sdaPadOut  = strobe.bypass ? sdaReq : held;

endmodule

// File: rtl/sda_glitch_filter.sv
module sda_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sdaPadIn,
  output logic sdaIn
);

  logic [FILT_LEN-2:0] smp;
  logic [FILT_LEN-1:0] window;
  logic                filt;

  // Current sample joined with the previous FILT_LEN-1 samples
  assign window = {smp, sdaPadIn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= '1;
      filt <= 1'b1;
    end else begin
      smp <= window[FILT_LEN-2:0];
      if (&window)       filt <= 1'b1;
      else if (~|window) filt <= 1'b0;
    end
  end

  assign sdaIn = enable ? filt : sdaPadIn;

endmodule

// File: rtl/sda_line_conditioner.sv
module sda_line_conditioner
  import sda_cond_pkg::*;
#(
  parameter int STEP     = 5,
  parameter int CODE_W   = 2,
  parameter int FILT_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CODE_W:0] lineCtrl,
  input  logic          sdaReq,
  input  logic          sdaPadIn,
  output logic          sdaPadOut,
  output logic          sdaIn
);

  localparam int FILT_BIT = CODE_W;

  sdaStrobe_t strobe;
  logic       reqChanged;

  sda_delay_ctrl #(.STEP(STEP), .CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (lineCtrl[CODE_W-1:0]),
    .reqChanged (reqChanged),
    .strobe     (strobe)
  );

  sda_delay_path u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdaReq     (sdaReq),
    .strobe     (strobe),
    .reqChanged (reqChanged),
    .sdaPadOut  (sdaPadOut)
  );

  sda_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (lineCtrl[FILT_BIT]),
    .sdaPadIn (sdaPadIn),
    .sdaIn    (sdaIn)
  );

endmodule

// File: rtl/sda_line_conditioner_chk.sv
module sda_line_conditioner_chk #(
  parameter int CODE_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CODE_W:0] lineCtrl,
  input logic          sdaReq,
  input logic          sdaPadIn,
  input logic          sdaPadOut,
  input logic          sdaIn
);

  logic [CODE_W-1:0] code;
  assign code = lineCtrl[CODE_W-1:0];

  // R2: code 0 drives the pad straight from the request
  p_bypass_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (sdaPadOut == sdaReq));

  // R3: with a steady nonzero code the pad only moves to the level last requested
  p_drive_from_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != '0) && ($past(code) == code) && (sdaPadOut != $past(sdaPadOut)))
      |-> (sdaPadOut == $past(sdaReq)));

  // R5: a filtered change needs the raw level on the preceding samples
  p_filter_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lineCtrl[CODE_W] && $past(lineCtrl[CODE_W]) && (sdaIn != $past(sdaIn)))
      |-> (($past(sdaPadIn) == sdaIn) && ($past(sdaPadIn, 2) == sdaIn)));

  // R7: leaving reset, both directions start released
  p_reset_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((!lineCtrl[CODE_W] || sdaIn) && ((code == '0) || sdaPadOut)));

endmodule

bind sda_line_conditioner sda_line_conditioner_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lineCtrl  (lineCtrl),
  .sdaReq    (sdaReq),
  .sdaPadIn  (sdaPadIn),
  .sdaPadOut (sdaPadOut),
  .sdaIn     (sdaIn)
);

// File: tb/sda_line_conditioner_test.sv
`timescale 1ns/1ps
module sda_line_conditioner_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lineCtrl = 3'b011;
  logic       sdaReq = 1'b0;
  logic       sdaPadIn = 1'b0;
  logic       sdaPadOut;
  logic       sdaIn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sda_line_conditioner uut (
    .clk(clk), .rst_n(rst_n), .lineCtrl(lineCtrl),
    .sdaReq(sdaReq), .sdaPadIn(sdaPadIn),
    .sdaPadOut(sdaPadOut), .sdaIn(sdaIn)
  );

  // Delay vectors: code, expected edges (5 per step, R3; code 0 is R2)
  localparam int DLY_CODE [4] = '{0, 1, 2, 3};
  // Filter vectors: pulse length in cycles, whether it must be accepted (R5)
  localparam int FLT_LEN [4] = '{1, 2, 3, 6};
  localparam int FLT_ACC [4] = '{0, 0, 1, 1};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until sdaPadOut equals lvl (0 if it already does)
  task automatic edges_until_out(input logic lvl, output int n);
    n = 0;
    #0.5;
    while (sdaPadOut != lvl && n < 40) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic edges_until_in(input logic lvl, output int n);
    n = 0;
    #0.5;
    while (sdaIn != lvl && n < 40) begin
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    logic seenLow;
    logic stayedHigh;

    // R7: reset values with a low request, a low pad and the filter on
    lineCtrl = 3'b111; sdaReq = 1'b0; sdaPadIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 drive released in reset", sdaPadOut, 1);
    check("R7 filter output high in reset", sdaIn, 1);
    sdaPadIn = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    // counter cleared: the held low request reaches the pad 15 edges later
    edges_until_out(1'b0, n);
    check("R7 delay from cleared counter", n, 15);

    // R3 / R2: delay table, both directions
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lineCtrl = {1'b0, DLY_CODE[i][1:0]};
      sdaReq = 1'b1;
      repeat (20) @(negedge clk);
      check("R3 settled high", sdaPadOut, 1);
      sdaReq = 1'b0;
      edges_until_out(1'b0, n);
      check(DLY_CODE[i] == 0 ? "R2 fall delay" : "R3 fall delay", n, DLY_CODE[i] * 5);
      @(negedge clk); repeat (20) @(negedge clk);
      sdaReq = 1'b1;
      edges_until_out(1'b1, n);
      check(DLY_CODE[i] == 0 ? "R2 rise delay" : "R3 rise delay", n, DLY_CODE[i] * 5);
    end

    // R4: short request pulse absorbed with code 1 (R1 code field)
    @(negedge clk);
    lineCtrl = 3'b001; sdaReq = 1'b1;
    repeat (20) @(negedge clk);
    sdaReq = 1'b0;
    stayedHigh = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(posedge clk); #1;
      if (!sdaPadOut) stayedHigh = 1'b0;
      @(negedge clk);
      if (k == 2) sdaReq = 1'b1;
    end
    check("R4 short pulse absorbed", stayedHigh, 1);

    // R4: restart on each change, output follows the last change
    @(negedge clk);
    sdaReq = 1'b0;
    stayedHigh = 1'b1;
    repeat (3) begin @(posedge clk); #1; if (!sdaPadOut) stayedHigh = 1'b0; end
    @(negedge clk); sdaReq = 1'b1;
    repeat (2) begin @(posedge clk); #1; if (!sdaPadOut) stayedHigh = 1'b0; end
    @(negedge clk); sdaReq = 1'b0;
    edges_until_out(1'b0, n);
    check("R4 no early drive during restarts", stayedHigh, 1);
    check("R4 delay from last change", n, 5);

    // R5: filter pulse table (R1 filter enable in bit 2)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lineCtrl = 3'b100; sdaPadIn = 1'b1;
      repeat (6) @(negedge clk);
      sdaPadIn = 1'b0;
      seenLow = 1'b0;
      for (int k = 0; k < FLT_LEN[i] + 5; k++) begin
        @(posedge clk); #1;
        if (!sdaIn) seenLow = 1'b1;
        @(negedge clk);
        if (k == FLT_LEN[i] - 1) sdaPadIn = 1'b1;
      end
      check("R5 pulse acceptance", seenLow, FLT_ACC[i]);
      check("R5 back to high", sdaIn, 1);
    end

    // R5: acceptance on the third edge
    @(negedge clk); sdaPadIn = 1'b0;
    edges_until_in(1'b0, n);
    check("R5 filter latency fall", n, 3);
    @(negedge clk); sdaPadIn = 1'b1;
    edges_until_in(1'b1, n);
    check("R5 filter latency rise", n, 3);

    // R6 / R1: filter disabled passes the raw level unchanged
    @(negedge clk); lineCtrl = 3'b000;
    sdaPadIn = 1'b0; #0.5;
    check("R6 bypass low", sdaIn, 0);
    @(negedge clk); sdaPadIn = 1'b1; #0.5;
    check("R6 bypass high", sdaIn, 1);
    @(negedge clk); sdaPadIn = 1'b0; #0.5;
    check("R1 bit 2 clear disables filter", sdaIn, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule